// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Programmable Triggers

This block gathers sixteen external request lines and presents at most one of them to a processor through a single request output. Each line is first brought into the clock domain through a two-flop synchroniser. It is then treated according to its own two-bit trigger mode: active-low level, active-high level, falling edge or rising edge. Each line also carries its own eight-bit priority level, and a level of zero switches the line off.

Edge events are held in a per-line latch until software clears it with a command write. Among the lines that are pending, enabled and above a global threshold, the one with the highest level wins. Ties go to the lowest line number. The winner's number and the low three bits of its level appear in a current-status word, together with an inverted "nothing presented" flag. All settings travel over a simple 32-bit word bus with combinational read data.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero, except the current-status word at 0xA0, which reads 0x0001_0000 (bit 16 set, nothing presented), and the request output is low.
- R2: Registers read back what was written: enable bit 0 at 0x00, mode words at 0x04/0x08 (16 bits each), level words at 0x10..0x2C (16 bits each), threshold bits 7:0 at 0x40. Any unmapped offset (for example 0x0C) reads zero even after a write.
- R3: While enable bit 0 is 0, nothing is presented: bit 16 of current-status is 1 and the request output is low, whatever the lines do.
- R4: Line n takes its mode from word 0x04 + 4*(n/8), bits (n mod 8)*2+1 : (n mod 8)*2. Code 00 makes it pending while the line is low, and code 01 while it is high.
- R5: Code 10 latches a pending event on a falling edge and code 11 on a rising edge. The latch stays set after the line returns, and the opposite edge sets nothing.
- R6: A write to 0x60 with bit 8 set clears the edge latch of the line numbered in bits 3:0. With bit 8 clear, or for another line number, the latch is untouched.
- R7: Line n takes its level from word 0x10 + 4*(n/2), bits (n&1)*8+7 : (n&1)*8. A level of 0 keeps the line from ever being presented.
- R8: Only a line whose level is strictly greater than the threshold at 0x40 can be presented. A threshold write changes the presented status within a few cycles.
- R9: The presented line is the eligible one with the highest level. Among equal levels, the lowest line number wins.
- R10: Current-status at 0xA0 has bit 16 = 0 when a line is presented and 1 otherwise. Bits 10:8 hold the low 3 bits of the winner's level and bits 4:0 its number. The request output is high exactly when bit 16 is 0.
- R11: A read of 0x80 returns the synchronised line values in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_pins_i | input | 16 | Asynchronous request lines |
| irq_req_o | output | 1 | Request to the processor |

## Verification
Each trigger code is driven through both polarities of its line. This shows whether a level source follows the line while an edge source keeps its event after the line returns. The edge test also applies the opposite edge and clear commands that lack bit 8 or name another line, which tells a correct clear decode from a loose one. For arbitration, three lines are raised together: two share a level of 9, one sits at a lower level of 5, and lines are dropped one by one. This separates level ordering from the number-based tie break and exposes the 3-bit truncation of the reported level. Threshold values equal to and just below a line's level locate the strict comparison.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned LVL_W  = 8;
    localparam int unsigned NUM_W  = 5;   // width of source number field in status
    localparam int unsigned RLVL_W = 3;   // width of reported level field

    // word indices (byte offset / 4)
    localparam int unsigned W_ENABLE = 0;
    localparam int unsigned W_MODE0  = 1;
    localparam int unsigned W_LVL0   = 4;
    localparam int unsigned W_MASK   = 16;
    localparam int unsigned W_CLR    = 24;
    localparam int unsigned W_PINS   = 32;
    localparam int unsigned W_CUR    = 40;

    localparam int unsigned CLR_EN_BIT = 8;
    localparam int unsigned SRC_PER_MODE_WORD = 8;
    localparam int unsigned SRC_PER_LVL_WORD  = 2;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef struct packed {
        logic              idle;
        logic [RLVL_W-1:0] lvl;
        logic [NUM_W-1:0]  src;
    } cur_stat_t;

    function automatic logic trig_is_edge(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic [31:0] pack_status(input cur_stat_t s);
        logic [31:0] w;
        w = '0;
        w[16]   = s.idle;
        w[10:8] = s.lvl;
        w[4:0]  = s.src;
        return w;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_SRC-1:0]            pins_sync_i,
    input  logic [31:0]                   cur_word_i,
    output logic                          en_o,
    output logic [NUM_SRC-1:0][1:0]       mode_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o,
    output logic [LVL_W-1:0]              mask_o,
    output logic                          clr_req_o,
    output logic [IDX_W-1:0]              clr_idx_o
);
    localparam int unsigned MODE_WORDS = NUM_SRC / SRC_PER_MODE_WORD;
    localparam int unsigned LVL_WORDS  = NUM_SRC / SRC_PER_LVL_WORD;

    logic [31:0] widx;
    logic        wr_en;

    logic                          en_q;
    logic [NUM_SRC-1:0][1:0]       mode_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0]              mask_q;

    assign widx  = 32'(bus_addr[ADDR_W-1:2]);
    assign wr_en = bus_sel & bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= '0;
            lvl_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (widx == W_ENABLE) en_q <= bus_wdata[0];
            if (widx == W_MASK)   mask_q <= bus_wdata[LVL_W-1:0];
            for (int w = 0; w < MODE_WORDS; w++) begin
                if (widx == W_MODE0 + w) begin
                    for (int k = 0; k < SRC_PER_MODE_WORD; k++)
                        mode_q[w*SRC_PER_MODE_WORD + k] <= bus_wdata[2*k +: 2];
                end
            end
            for (int w = 0; w < LVL_WORDS; w++) begin
                if (widx == W_LVL0 + w) begin
                    for (int k = 0; k < SRC_PER_LVL_WORD; k++)
                        lvl_q[w*SRC_PER_LVL_WORD + k] <= bus_wdata[k*LVL_W +: LVL_W];
                end
            end
        end
    end

    // Clear command acts at the same edge as the bus write
    assign clr_req_o = wr_en && (widx == W_CLR) && bus_wdata[CLR_EN_BIT];
    assign clr_idx_o = bus_wdata[IDX_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (widx == W_ENABLE) bus_rdata[0] = en_q;
        if (widx == W_MASK)   bus_rdata[LVL_W-1:0] = mask_q;
        if (widx == W_PINS)   bus_rdata[NUM_SRC-1:0] = pins_sync_i;
        if (widx == W_CUR)    bus_rdata = cur_word_i;
        for (int w = 0; w < MODE_WORDS; w++) begin
            if (widx == W_MODE0 + w) begin
                for (int k = 0; k < SRC_PER_MODE_WORD; k++)
                    bus_rdata[2*k +: 2] = mode_q[w*SRC_PER_MODE_WORD + k];
            end
        end
        for (int w = 0; w < LVL_WORDS; w++) begin
            if (widx == W_LVL0 + w) begin
                for (int k = 0; k < SRC_PER_LVL_WORD; k++)
                    bus_rdata[k*LVL_W +: LVL_W] = lvl_q[w*SRC_PER_LVL_WORD + k];
            end
        end
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign lvl_o  = lvl_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/irqc_trig.sv
module irqc_trig
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = $clog2(NUM_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SRC-1:0]      pins_i,
    input  logic [NUM_SRC-1:0][1:0] mode_i,
    input  logic                    clr_req_i,
    input  logic [IDX_W-1:0]        clr_idx_i,
    output logic [NUM_SRC-1:0]      sync_o,
    output logic [NUM_SRC-1:0]      pend_o
);
    logic [SYNC_STAGES-1:0][NUM_SRC-1:0] chain_q;
    logic [NUM_SRC-1:0] sync, prev_q, latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pins_i};
            prev_q  <= sync;
        end
    end

    assign sync   = chain_q[SYNC_STAGES-1];
    assign sync_o = sync;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic rise, fall, hit, clr_hit, is_edge;

        assign rise    = sync[i] & ~prev_q[i];
        assign fall    = ~sync[i] & prev_q[i];
        assign hit     = mode_i[i][0] ? rise : fall;
        assign clr_hit = clr_req_i && (clr_idx_i == IDX_W'(i));
        assign is_edge = trig_is_edge(mode_i[i]);

        // a new edge wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst)          latch_q[i] <= 1'b0;
            else if (!is_edge) latch_q[i] <= 1'b0;
            else if (hit)     latch_q[i] <= 1'b1;
            else if (clr_hit) latch_q[i] <= 1'b0;
        end

        assign pend_o[i] = is_edge ? latch_q[i] : (sync[i] == mode_i[i][0]);

        // R5
        latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
            latch_q[i] && is_edge && !clr_hit |=> latch_q[i]);

        // R6
        latch_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(latch_q[i]) |-> ($past(clr_hit) || !$past(is_edge)));
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            elig_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    output logic                          win_valid_o,
    output logic [IDX_W-1:0]              win_idx_o,
    output logic [LVL_W-1:0]              win_lvl_o
);
    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (!win_valid_o || lvl_i[i] >= win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_lvl_o   = lvl_i[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R9
        no_higher_loser_chk: assert property (@(posedge clk) disable iff (rst)
            elig_i[i] |-> (win_valid_o && lvl_i[i] <= win_lvl_o));

        // R9
        tie_low_index_chk: assert property (@(posedge clk) disable iff (rst)
            elig_i[i] && lvl_i[i] == win_lvl_o |-> win_idx_o <= IDX_W'(i));
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_pins_i,
    output logic               irq_req_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic                          en;
    logic [NUM_SRC-1:0][1:0]       mode;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [LVL_W-1:0]              mask;
    logic                          clr_req;
    logic [IDX_W-1:0]              clr_idx;
    logic [NUM_SRC-1:0]            sync, pend, elig;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    logic [LVL_W-1:0]              win_lvl;
    cur_stat_t                     stat_q;

    irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_sync_i(sync), .cur_word_i(pack_status(stat_q)),
        .en_o(en), .mode_o(mode), .lvl_o(lvl), .mask_o(mask),
        .clr_req_o(clr_req), .clr_idx_o(clr_idx)
    );

    irqc_trig #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) trig_i (
        .clk(clk), .rst(rst), .pins_i(irq_pins_i), .mode_i(mode),
        .clr_req_i(clr_req), .clr_idx_i(clr_idx),
        .sync_o(sync), .pend_o(pend)
    );

    // level above threshold; a zero level can never exceed any threshold
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = en && pend[i] && (lvl[i] > mask);
    end

    irqc_arb #(.NUM_SRC(NUM_SRC)) arb_i (
        .clk(clk), .rst(rst), .elig_i(elig), .lvl_i(lvl),
        .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
    );

    // status re-evaluated every cycle, so any threshold write takes effect
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{idle: 1'b1, lvl: '0, src: '0};
        end else if (win_valid) begin
            stat_q <= '{idle: 1'b0, lvl: win_lvl[RLVL_W-1:0], src: NUM_W'(win_idx)};
        end else begin
            stat_q <= '{idle: 1'b1, lvl: '0, src: '0};
        end
    end

    assign irq_req_o = ~stat_q.idle;

    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> stat_q.idle);

    // R7 R8
    winner_above_mask_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (lvl[win_idx] > mask && lvl[win_idx] != '0 && pend[win_idx]));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pins = '0;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pins_i(pins), .irq_req_o(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] p);
        @(negedge clk);
        pins = p;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_cs(input string tag, input logic [31:0] exp);
        logic [31:0] v;
        rd(8'hA0, v);
        chk(tag, v, exp);
        chk({tag, " R10 req"}, {31'd0, irq_req}, {31'd0, ~exp[16]});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset(16'h0000);
        for (int a = 0; a < 8'hA0; a += 4) begin
            rd(8'(a), v);
            chk("R1 reg zero", v, 32'h0);
        end
        chk_cs("R1 status", 32'h0001_0000);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset(16'h0000);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 enable", v, 32'h1);
        wr(8'h04, 32'h1234_A5C3); rd(8'h04, v); chk("R2 mode0", v, 32'h0000_A5C3);
        wr(8'h08, 32'h0000_5A3C); rd(8'h08, v); chk("R2 mode1", v, 32'h0000_5A3C);
        wr(8'h2C, 32'hFFFF_BEEF); rd(8'h2C, v); chk("R2 level7", v, 32'h0000_BEEF);
        wr(8'h40, 32'h0000_0177); rd(8'h40, v); chk("R2 mask", v, 32'h0000_0077);
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R2 unmapped", v, 32'h0);
        rd(8'h60, v); chk("R2 clr reads zero", v, 32'h0);
    endtask

    task automatic t_level_modes();
        do_reset(16'hFFFF);
        wr(8'h18, 32'h0000_0300);          // source 5 level 3
        wr(8'h00, 32'h1);
        settle(); chk_cs("R4 low idle", 32'h0001_0000);
        @(negedge clk); pins[5] = 1'b0;
        settle(); chk_cs("R4 low active", 32'h0000_0305);
        wr(8'h00, 32'h0);
        settle(); chk_cs("R3 disabled", 32'h0001_0000);
        wr(8'h00, 32'h1);
        settle(); chk_cs("R3 re-enabled", 32'h0000_0305);
        wr(8'h04, 32'h0000_0400);          // source 5 active-high
        settle(); chk_cs("R4 high while low", 32'h0001_0000);
        @(negedge clk); pins[5] = 1'b1;
        settle(); chk_cs("R4 high active", 32'h0000_0305);
    endtask

    task automatic t_edges();
        do_reset(16'h0000);
        wr(8'h24, 32'h0000_0006);          // source 10 level 6
        wr(8'h08, 32'h0000_0030);          // source 10 rising
        wr(8'h00, 32'h1);
        settle(); chk_cs("R5 no edge", 32'h0001_0000);
        @(negedge clk); pins[10] = 1'b1;
        settle(); chk_cs("R5 rise latched", 32'h0000_060A);
        @(negedge clk); pins[10] = 1'b0;
        settle(); chk_cs("R5 latch holds", 32'h0000_060A);
        wr(8'h60, 32'h0000_000A);
        settle(); chk_cs("R6 no bit8", 32'h0000_060A);
        wr(8'h60, 32'h0000_0103);
        settle(); chk_cs("R6 other index", 32'h0000_060A);
        wr(8'h60, 32'h0000_010A);
        settle(); chk_cs("R6 cleared", 32'h0001_0000);
        wr(8'h08, 32'h0000_0020);          // source 10 falling
        @(negedge clk); pins[10] = 1'b1;
        settle(); chk_cs("R5 rise ignored in fall mode", 32'h0001_0000);
        @(negedge clk); pins[10] = 1'b0;
        settle(); chk_cs("R5 fall latched", 32'h0000_060A);
    endtask

    task automatic t_levels_mask();
        do_reset(16'h0000);
        wr(8'h04, 32'h0000_0400);          // source 5 active-high
        wr(8'h00, 32'h1);
        @(negedge clk); pins[5] = 1'b1;
        settle(); chk_cs("R7 level zero", 32'h0001_0000);
        wr(8'h18, 32'h0000_0100);
        settle(); chk_cs("R7 level one", 32'h0000_0105);
        wr(8'h18, 32'h0000_0400);
        wr(8'h40, 32'h4);
        settle(); chk_cs("R8 equal to mask", 32'h0001_0000);
        wr(8'h40, 32'h3);
        settle(); chk_cs("R8 above mask", 32'h0000_0405);
        wr(8'h40, 32'h4);
        settle(); chk_cs("R8 mask raised", 32'h0001_0000);
    endtask

    task automatic t_arbitration();
        do_reset(16'h0000);
        wr(8'h14, 32'h0000_0005);          // source 2 level 5
        wr(8'h1C, 32'h0000_0900);          // source 7 level 9
        wr(8'h28, 32'h0000_0009);          // source 12 level 9
        wr(8'h04, 32'h0000_4010);          // sources 2,7 active-high
        wr(8'h08, 32'h0000_0100);          // source 12 active-high
        wr(8'h00, 32'h1);
        @(negedge clk); pins = 16'h1084;
        settle(); chk_cs("R9 tie low index", 32'h0000_0107);
        @(negedge clk); pins[7] = 1'b0;
        settle(); chk_cs("R9 next highest", 32'h0000_010C);
        @(negedge clk); pins[12] = 1'b0;
        settle(); chk_cs("R9 lowest remaining", 32'h0000_0502);
    endtask

    task automatic t_pins();
        logic [31:0] v;
        do_reset(16'h0000);
        @(negedge clk); pins = 16'hBEEF;
        settle(); rd(8'h80, v); chk("R11 pins", v, 32'h0000_BEEF);
        @(negedge clk); pins = 16'h1234;
        settle(); rd(8'h80, v); chk("R11 pins again", v, 32'h0000_1234);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_level_modes();
        t_edges();
        t_levels_mask();
        t_arbitration();
        t_pins();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule